// File: doc/BRIEF.md
# Posted Write Buffer with Burst Drain

This block lets a processor core post memory writes and move on without waiting for main memory. Each write (address, data, byte enables) goes into a four-entry first-in first-out store on a valid/ready push port. The core only sees back-pressure when every slot is taken and no slot is being freed in that cycle. Behind the store, a drain engine empties the entries onto a 32-bit external bus, oldest first. It asks for the bus only while no other master is using it, and it keeps the request up until a grant comes back.

The drain engine chooses the transfer shape when it raises its request. If the store is completely full and all four addresses share one aligned 16-byte block, it runs one four-beat burst. Otherwise it moves a single entry as a one-beat transaction. A memory-side acknowledge retires each beat. An empty flag lets later logic, such as a read-miss handler, wait until all posted writes have reached memory.

Push rules: a write transfers on a rising clock edge when `push_valid` and `push_ready` are both high. `push_ready` is low only when all four slots are occupied and no beat is being acknowledged in that cycle. When a beat is acknowledged in the same cycle, a push into the full store is accepted.

Top module: `posted_wr_buf`

## Requirements
- R1: The store holds four entries. `buf_full` is 1 exactly when four entries are held.
- R2: While fewer than four entries are held, `push_ready` is 1, whatever the external bus is doing.
- R3: Entries leave in the order they were accepted. Each beat carries the accepted address, data and byte enables unchanged.
- R4: `bus_req` only rises in a cycle after one where `ext_busy` was 0. While `ext_busy` stays 1 and no transaction is open, `bus_req` stays 0.
- R5: Once raised, `bus_req` stays 1 until `bus_gnt` is seen, and then through the transfer. It drops only after the acknowledged beat that has `bus_last` = 1.
- R6: A beat stays on the bus (`bus_valid` = 1, with address, data, byte enables, `bus_burst` and `bus_last` unchanged) until `bus_ack` is 1 in that cycle. Each acknowledge retires exactly one entry.
- R7: A transaction that starts with four entries held, all with equal address bits [31:4], is a burst. It has four beats, `bus_burst` = 1 on each, and `bus_last` = 1 only on the fourth.
- R8: Every other transaction is a single beat with `bus_burst` = 0 and `bus_last` = 1.
- R9: `push_ready` is 0 only when four entries are held and no beat is being acknowledged in that cycle.
- R10: If a push is accepted in the same cycle a beat is acknowledged, both take effect and the entry count does not change (a full store stays full).
- R11: `buf_empty` is 1 exactly when no entry is held. No beat is presented while the store is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Core offers a write |
| push_ready | output | 1 | Buffer accepts the offered write |
| push_addr | input | 32 | Byte address of the write |
| push_data | input | 32 | Write data |
| push_be | input | 4 | Byte enables |
| ext_busy | input | 1 | Another master is using the external bus |
| bus_req | output | 1 | Request for the external bus |
| bus_gnt | input | 1 | Grant for the external bus |
| bus_valid | output | 1 | A beat is presented |
| bus_addr | output | 32 | Beat address |
| bus_data | output | 32 | Beat data |
| bus_be | output | 4 | Beat byte enables |
| bus_burst | output | 1 | Beat belongs to a four-beat burst |
| bus_last | output | 1 | Final beat of the transaction |
| bus_ack | input | 1 | Memory side retires the presented beat |
| buf_empty | output | 1 | No entry held |
| buf_full | output | 1 | All four entries held |

## Verification
The assertions assume the memory side behaves: `bus_ack` is raised only while `bus_valid` is 1, and `bus_gnt` is raised only while a request is open and no beat is yet presented. The bench's responder builds grant and acknowledge only from the block's own `bus_req` and `bus_valid`, with a programmed delay, so it never goes outside those rules. The one hand-driven acknowledge is also raised only after `bus_valid` has been seen high. The bench sweeps all sixteen ways four entries can split across two 16-byte blocks, under several grant and acknowledge delays.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } wr_entry_t;

  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_REQ  = 2'd1,
    DR_XFER = 2'd2
  } drain_st_e;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo
  import pwb_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned TAG_LSB = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  wr_entry_t wr_entry,
  input  logic      rd_en,
  output wr_entry_t head,
  output logic [ADDR_W-TAG_LSB-1:0] tags [DEPTH],
  output logic      empty,
  output logic      full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  wr_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_step(wr_ptr);
      if (rd_en) rd_ptr <= ptr_step(rd_ptr);
      unique case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = slot_q[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_MAX);

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    assign tags[i] = slot_q[i].addr[ADDR_W-1:TAG_LSB];
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en |-> rd_en);

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_en);

  // R10
  cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en |=> $stable(count));
endmodule

// File: rtl/pwb_blk_match.sv
module pwb_blk_match #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 28
) (
  input  logic [TAG_W-1:0] tags [DEPTH],
  output logic             same_blk
);
  logic [DEPTH-1:0] hit;

  assign hit[0] = 1'b1;
  for (genvar i = 1; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = (tags[i] == tags[0]);
  end

  assign same_blk = &hit;
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
  import pwb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic empty,
  input  logic full,
  input  logic same_blk,
  input  logic ext_busy,
  input  logic bus_gnt,
  input  logic bus_ack,
  output logic bus_req,
  output logic bus_valid,
  output logic bus_burst,
  output logic bus_last,
  output logic pop
);
  localparam int unsigned BEAT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(DEPTH - 1);

  drain_st_e         st;
  logic              burst_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= DR_IDLE;
      burst_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      unique case (st)
        DR_IDLE: begin
          if (!empty && !ext_busy) begin
            st      <= DR_REQ;
            burst_q <= full && same_blk;
            beat_q  <= '0;
          end
        end
        DR_REQ: begin
          if (bus_gnt) st <= DR_XFER;
        end
        DR_XFER: begin
          if (bus_ack) begin
            if (bus_last) st <= DR_IDLE;
            else          beat_q <= beat_q + 1'b1;
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end

  assign bus_req   = (st != DR_IDLE);
  assign bus_valid = (st == DR_XFER);
  assign bus_burst = burst_q;
  assign bus_last  = !burst_q || (beat_q == BEAT_END);
  assign pop       = bus_valid && bus_ack;

  // R4
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(!ext_busy));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_valid && bus_ack && bus_last) |=> bus_req);

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_burst) && $stable(bus_last));

  // R7
  burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_burst && bus_ack && !bus_last |=> bus_valid && bus_burst);
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
  import pwb_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [BE_W-1:0]   push_be,
  input  logic              ext_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_burst,
  output logic              bus_last,
  input  logic              bus_ack,
  output logic              buf_empty,
  output logic              buf_full
);
  localparam int unsigned BLK_LSB = $clog2(BLK_BYTES);
  localparam int unsigned TAG_W   = ADDR_W - BLK_LSB;

  wr_entry_t        in_entry;
  wr_entry_t        head;
  logic [TAG_W-1:0] tags [DEPTH];
  logic             wr_en;
  logic             pop;
  logic             same_blk;

  assign in_entry = '{addr: push_addr, data: push_data, be: push_be};
  assign push_ready = !buf_full || pop;
  assign wr_en = push_valid && push_ready;

  pwb_fifo #(.DEPTH(DEPTH), .TAG_LSB(BLK_LSB)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_entry (in_entry),
    .rd_en    (pop),
    .head     (head),
    .tags     (tags),
    .empty    (buf_empty),
    .full     (buf_full)
  );

  pwb_blk_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .tags     (tags),
    .same_blk (same_blk)
  );

  pwb_drain #(.DEPTH(DEPTH)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .empty     (buf_empty),
    .full      (buf_full),
    .same_blk  (same_blk),
    .ext_busy  (ext_busy),
    .bus_gnt   (bus_gnt),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_valid (bus_valid),
    .bus_burst (bus_burst),
    .bus_last  (bus_last),
    .pop       (pop)
  );

  assign bus_addr = head.addr;
  assign bus_data = head.data;
  assign bus_be   = head.be;

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> $stable(bus_addr) && $stable(bus_data) && $stable(bus_be));

  // R11
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !bus_valid);
endmodule

// File: tb/tb_posted_wr_buf.sv
module tb_posted_wr_buf;
  import pwb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic push_ready;
  logic [31:0] push_addr = '0;
  logic [31:0] push_data = '0;
  logic [3:0]  push_be = '0;
  logic ext_busy = 1'b1;
  logic bus_req;
  logic bus_gnt = 1'b0;
  logic bus_valid;
  logic [31:0] bus_addr;
  logic [31:0] bus_data;
  logic [3:0]  bus_be;
  logic bus_burst;
  logic bus_last;
  logic bus_ack;
  logic buf_empty;
  logic buf_full;

  logic auto_ack = 1'b0;
  logic man_ack = 1'b0;
  bit   manual = 1'b0;
  assign bus_ack = manual ? man_ack : auto_ack;

  int n_chk = 0;
  int n_err = 0;
  int gnt_dly = 0;
  int ack_dly = 0;
  int exp_burst = 2;
  int beat_idx = 0;
  bit finished = 1'b0;
  wr_entry_t exp_q[$];

  always #2 clk = ~clk;

  posted_wr_buf dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_addr(push_addr), .push_data(push_data), .push_be(push_be),
    .ext_busy(ext_busy),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
    .bus_burst(bus_burst), .bus_last(bus_last), .bus_ack(bus_ack),
    .buf_empty(buf_empty), .buf_full(buf_full)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Compares the beat on the bus with the oldest outstanding write.
  task automatic check_beat();
    wr_entry_t e;
    logic exp_last;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 beat with nothing pending", bus_addr, 32'h0);
      return;
    end
    e = exp_q.pop_front();
    chk(bus_addr == e.addr, "R3 addr", bus_addr, e.addr);
    chk(bus_data == e.data, "R3 data", bus_data, e.data);
    chk(bus_be == e.be, "R3 be", {28'h0, bus_be}, {28'h0, e.be});
    if (exp_burst != 2) begin
      exp_last = (exp_burst == 1) ? (beat_idx == 3) : 1'b1;
      chk(bus_burst == exp_burst[0], "R7/R8 burst flag", {31'h0, bus_burst}, exp_burst);
      chk(bus_last == exp_last, "R7/R8 last flag", {31'h0, bus_last}, {31'h0, exp_last});
    end
    beat_idx = bus_last ? 0 : beat_idx + 1;
  endtask

  // Memory-side responder, driven at the falling edge.
  initial begin
    int gcnt = 0;
    int acnt = 0;
    bit held = 1'b0;
    bit pend = 1'b0;
    logic [31:0] h_addr = '0;
    logic [31:0] h_data = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bus_gnt = 1'b0; auto_ack = 1'b0; gcnt = 0; acnt = 0; held = 1'b0; pend = 1'b0;
        continue;
      end
      if (pend) chk(bus_req == 1'b1, "R5 request held", {31'h0, bus_req}, 32'h1);
      if (held && bus_valid) begin
        chk(bus_addr == h_addr, "R6 addr stable while waiting", bus_addr, h_addr);
        chk(bus_data == h_data, "R6 data stable while waiting", bus_data, h_data);
      end
      if (bus_req && !bus_valid) begin
        if (gcnt >= gnt_dly) bus_gnt = 1'b1;
        else begin bus_gnt = 1'b0; gcnt++; end
      end else begin
        bus_gnt = 1'b0; gcnt = 0;
      end
      if (manual) begin
        auto_ack = 1'b0; held = 1'b0; pend = 1'b0;
      end else begin
        if (bus_valid && acnt >= ack_dly) begin
          auto_ack = 1'b1; acnt = 0; check_beat();
        end else begin
          auto_ack = 1'b0;
          if (bus_valid) acnt++;
        end
        held = bus_valid && !auto_ack;
        h_addr = bus_addr; h_data = bus_data;
        pend = bus_req && !(bus_valid && auto_ack && bus_last);
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    push_valid = 1'b1; push_addr = a; push_data = d; push_be = b;
    #1;
    while (!push_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back('{addr: a, data: d, be: b});
    @(posedge clk);
    #1 push_valid = 1'b0;
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0 || !buf_empty) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(buf_empty == 1'b1, "R11 empty after drain", {31'h0, buf_empty}, 32'h1);
    chk(bus_req == 1'b0, "R5 request dropped after last beat", {31'h0, bus_req}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(buf_empty == 1'b1, "R11 reset empty", {31'h0, buf_empty}, 32'h1);
    chk(buf_full == 1'b0, "R1 reset not full", {31'h0, buf_full}, 32'h0);
    chk(bus_req == 1'b0, "R4 reset no request", {31'h0, bus_req}, 32'h0);
    chk(push_ready == 1'b1, "R2 reset ready", {31'h0, push_ready}, 32'h1);
    rst_n = 1'b1;

    // Sweep every split of four entries across two adjacent 16-byte blocks.
    for (int m = 0; m < 16; m++) begin
      logic [31:0] base;
      base = 32'h1000_0000 + 32'(m) * 32'h40;
      gnt_dly = m % 3;
      ack_dly = (m / 3) % 2;
      @(negedge clk); ext_busy = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #1;
        chk(push_ready == 1'b1, "R2 ready below four entries", {31'h0, push_ready}, 32'h1);
        chk(buf_full == 1'b0, "R1 not full below four", {31'h0, buf_full}, 32'h0);
        push(base + 32'((m >> i) & 1) * 32'h10 + 32'(i) * 4,
             32'hC0DE_0000 + 32'(m) * 16 + 32'(i), 4'(1 << i) | 4'(m));
      end
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        chk(buf_full == 1'b1, "R1 full at four", {31'h0, buf_full}, 32'h1);
        chk(push_ready == 1'b0, "R9 not ready when full", {31'h0, push_ready}, 32'h0);
        chk(bus_req == 1'b0, "R4 no request while busy", {31'h0, bus_req}, 32'h0);
      end
      exp_burst = (m == 0 || m == 15) ? 1 : 0;
      beat_idx = 0;
      @(negedge clk); ext_busy = 1'b0;
      wait_drained();
    end

    // Streaming with the bus free: order only.
    exp_burst = 2;
    beat_idx = 0;
    for (int i = 0; i < 40; i++) begin
      ack_dly = i % 3;
      gnt_dly = (i / 3) % 2;
      push(32'h2000_0000 + 32'(i) * 52, 32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000, 4'(i + 1));
    end
    wait_drained();

    // Push accepted in the same cycle as an acknowledge on a full store.
    manual = 1'b1;
    gnt_dly = 0;
    exp_burst = 0;
    beat_idx = 0;
    @(negedge clk); ext_busy = 1'b1;
    for (int i = 0; i < 4; i++)
      push(32'h3000_0000 + 32'((5 >> i) & 1) * 32'h10 + 32'(i) * 4, 32'h5A00_0000 + 32'(i), 4'hF);
    @(negedge clk); ext_busy = 1'b0;
    @(negedge clk);
    while (!bus_valid) @(negedge clk);
    man_ack = 1'b1;
    push_valid = 1'b1; push_addr = 32'h3000_0100; push_data = 32'h5A00_00FF; push_be = 4'h3;
    #1;
    chk(push_ready == 1'b1, "R9 ready while a beat retires", {31'h0, push_ready}, 32'h1);
    check_beat();
    exp_q.push_back('{addr: 32'h3000_0100, data: 32'h5A00_00FF, be: 4'h3});
    @(posedge clk);
    #1 man_ack = 1'b0; push_valid = 1'b0;
    @(negedge clk);
    chk(buf_full == 1'b1, "R10 count unchanged on push plus pop", {31'h0, buf_full}, 32'h1);
    manual = 1'b0;
    wait_drained();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule